// File: doc/BRIEF.md
# Wait-State Address Hold Adapter

This adapter sits between a small 8-bit processor core and on-chip synchronous RAM. The core drives its 16-bit address combinationally, so that a clocked RAM can take the address in the same cycle it is formed. In some access states the core builds that address straight from the byte on its incoming data bus, as it does for a zero-page operand. While the ready input is low the core is frozen. The data bus, however, is free to move on, and the live address moves with it. Without this adapter the memory would be handed a wrong address while the core waits.

In the default pass-through variant, the live address and write signals go straight to the memory while ready is high. In the first cycle ready is low, the address and write data are still live, and they are captured at the end of that cycle. In the following stall cycles the captured values are presented until ready rises. At that point the live values return in the same cycle. The write strobe is held off during any stall, so each write reaches the memory exactly once, in the cycle in which the access completes.

A second variant, selected by a parameter, registers the address, write strobe and write data. Ready acts as the clock enable of those registers. This variant suits memories that want a registered address and needs no hold path.

Top module: `addr_hold_adapter`

## Requirements
- R1: Pass-through variant: while rdy is 1 and rst is 0, mem_addr equals core_addr, mem_wdata equals core_wdata and mem_we equals core_we, all in the same cycle.
- R2: Pass-through variant: in the first cycle with rdy at 0 (the previous cycle had rdy at 1 or was a reset cycle), mem_addr and mem_wdata still show the live core values, and those values are captured at the closing clock edge.
- R3: Pass-through variant: in every later cycle of an unbroken rdy-low run, mem_addr equals the address captured under R2, whatever core_addr does.
- R4: Pass-through variant: during those later stall cycles, mem_wdata equals the write data captured under R2, whatever core_wdata does.
- R5: Pass-through variant: mem_we is 0 in every cycle with rdy at 0. A write is therefore issued once, in its completion cycle.
- R6: Pass-through variant: in the cycle rdy returns to 1, the outputs show the live core values again, with no added cycle.
- R7: Synchronous active-high reset clears the stall tracking and the held values. While rst is 1 the pass-through variant shows live values. A stall that is already under way when reset ends counts as a fresh first stall cycle. The registered variant reads 0 on every output after a reset edge.
- R8: Registered variant: at a clock edge with rdy at 1, mem_addr, mem_we and mem_wdata take the core values, which appear from the next cycle on.
- R9: Registered variant: after an edge with rdy at 0, mem_addr and mem_wdata are unchanged and mem_we is 0.
- R10: With rdy driven low at random (a stall starts with probability 1/16 per cycle), the list of accesses the memory sees in ready cycles is identical to the list seen in a run without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy | input | 1 | Ready; 0 stalls the core |
| core_addr | input | ADDR_W | Combinational address from the core |
| core_we | input | 1 | Write strobe from the core |
| core_wdata | input | DATA_W | Write data from the core |
| mem_addr | output | ADDR_W | Address presented to the memory |
| mem_we | output | 1 | Write strobe presented to the memory |
| mem_wdata | output | DATA_W | Write data presented to the memory |

## Verification
A stall tracker that misses the first wait cycle shows up at the ports in the second stall cycle. In that cycle mem_addr follows the scrambled data-bus address instead of freezing, or it freezes one cycle too early on a value that was never captured. A hold register that loads at the wrong time, or a strobe that is not gated, shows up as a wrong address or as an extra write before the access completes. In the registered variant, an enable error shows one cycle after the offending edge. The bench drives a core model whose zero-page address follows a data bus that is scrambled during stalls. It checks every cycle and compares the access signatures of runs with and without stalls.

// File: rtl/ahold_pkg.sv
package ahold_pkg;

    // Where the output of the pass-through variant comes from this cycle
    typedef enum logic [1:0] {
        PH_LIVE  = 2'd0,   // ready, or in reset: live core values
        PH_FIRST = 2'd1,   // first stalled cycle: live values, capture at edge
        PH_HELD  = 2'd2    // later stalled cycles: captured values
    } phase_e;

    function automatic phase_e pick_phase(input logic rst,
                                          input logic rdy,
                                          input logic stalled_before);
        if (rst || rdy)
            return PH_LIVE;
        else if (!stalled_before)
            return PH_FIRST;
        else
            return PH_HELD;
    endfunction

    function automatic logic strobe_allowed(input phase_e ph, input logic rdy);
        return (ph == PH_LIVE) && rdy;
    endfunction

endpackage

// File: rtl/ahold_phase.sv
module ahold_phase
    import ahold_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rdy,
    output phase_e phase,
    output logic   capture
);
    logic stall_q;

    always_ff @(posedge clk) begin
        if (rst)
            stall_q <= 1'b0;
        else
            stall_q <= !rdy;
    end

    always_comb begin
        phase   = pick_phase(rst, rdy, stall_q);
        capture = (phase == PH_FIRST);
    end

    AST_HELD_NEEDS_STALL: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HELD) |-> $past(!rdy)) else $error("held without stall"); // R3

    AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FIRST) |=> (phase != PH_FIRST)) else $error("double first"); // R2

endmodule

// File: rtl/ahold_capture.sv
module ahold_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

    AST_CAPTURE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)) else $error("hold register drifted"); // R3

endmodule

// File: rtl/ahold_select.sv
module ahold_select
    import ahold_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  logic              rdy,
    input  logic [ADDR_W-1:0] live_addr,
    input  logic              live_we,
    input  logic [DATA_W-1:0] live_wdata,
    input  logic [ADDR_W-1:0] held_addr,
    input  logic [DATA_W-1:0] held_wdata,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_we,
    output logic [DATA_W-1:0] out_wdata
);
    always_comb begin
        case (phase)
            PH_HELD: begin
                out_addr  = held_addr;
                out_wdata = held_wdata;
            end
            default: begin
                out_addr  = live_addr;
                out_wdata = live_wdata;
            end
        endcase
        out_we = live_we && strobe_allowed(phase, rdy);
    end
endmodule

// File: rtl/ahold_regstage.sv
module ahold_regstage #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rdy,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
        end else begin
            if (rdy) begin
                mem_addr  <= core_addr;
                mem_wdata <= core_wdata;
            end
            mem_we <= rdy && core_we;
        end
    end

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
        rdy |=> (mem_addr == $past(core_addr))) else $error("reg load"); // R8

    AST_REG_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> ($stable(mem_addr) && $stable(mem_wdata))) else $error("reg freeze"); // R9

    AST_REG_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> !mem_we) else $error("reg repeat write"); // R9

endmodule

// File: rtl/addr_hold_adapter.sv
module addr_hold_adapter
    import ahold_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter bit REGISTERED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rdy,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    generate
        if (REGISTERED) begin : g_reg
            ahold_regstage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
                .clk        (clk),
                .rst        (rst),
                .rdy        (rdy),
                .core_addr  (core_addr),
                .core_we    (core_we),
                .core_wdata (core_wdata),
                .mem_addr   (mem_addr),
                .mem_we     (mem_we),
                .mem_wdata  (mem_wdata)
            );
        end else begin : g_hold
            phase_e            phase;
            logic              capture;
            logic [ADDR_W-1:0] held_addr;
            logic [DATA_W-1:0] held_wdata;

            ahold_phase u_phase (
                .clk     (clk),
                .rst     (rst),
                .rdy     (rdy),
                .phase   (phase),
                .capture (capture)
            );

            ahold_capture #(.W(ADDR_W)) u_cap_addr (
                .clk  (clk),
                .rst  (rst),
                .load (capture),
                .d    (core_addr),
                .q    (held_addr)
            );

            ahold_capture #(.W(DATA_W)) u_cap_data (
                .clk  (clk),
                .rst  (rst),
                .load (capture),
                .d    (core_wdata),
                .q    (held_wdata)
            );

            ahold_select #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
                .phase      (phase),
                .rdy        (rdy),
                .live_addr  (core_addr),
                .live_we    (core_we),
                .live_wdata (core_wdata),
                .held_addr  (held_addr),
                .held_wdata (held_wdata),
                .out_addr   (mem_addr),
                .out_we     (mem_we),
                .out_wdata  (mem_wdata)
            );

            AST_LIVE_ON_READY: assert property (@(posedge clk) disable iff (rst)
                rdy |-> (mem_addr == core_addr && mem_wdata == core_wdata))
                else $error("not live when ready"); // R6

            AST_NO_STALL_WRITE: assert property (@(posedge clk) disable iff (rst)
                !rdy |-> !mem_we) else $error("write during stall"); // R5

            AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
                (phase == PH_HELD) |-> ($stable(mem_addr) && $stable(mem_wdata)))
                else $error("held output moved"); // R4
        end
    endgenerate

endmodule

// File: tb/sim_addr_hold_adapter.sv
module sim_addr_hold_adapter;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rdy = 1'b1;
    logic [AW-1:0] core_addr = '0;
    logic          core_we = 1'b0;
    logic [DW-1:0] core_wdata = '0;

    logic [AW-1:0] a0_addr, a1_addr;
    logic          a0_we, a1_we;
    logic [DW-1:0] a0_wd, a1_wd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    addr_hold_adapter #(.ADDR_W(AW), .DATA_W(DW), .REGISTERED(1'b0)) u0 (
        .clk(clk), .rst(rst), .rdy(rdy),
        .core_addr(core_addr), .core_we(core_we), .core_wdata(core_wdata),
        .mem_addr(a0_addr), .mem_we(a0_we), .mem_wdata(a0_wd)
    );

    addr_hold_adapter #(.ADDR_W(AW), .DATA_W(DW), .REGISTERED(1'b1)) u1 (
        .clk(clk), .rst(rst), .rdy(rdy),
        .core_addr(core_addr), .core_we(core_we), .core_wdata(core_wdata),
        .mem_addr(a1_addr), .mem_we(a1_we), .mem_wdata(a1_wd)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Access list of the modelled core
    function automatic bit acc_zp(input int k);
        return (k % 4) == 1;
    endfunction
    function automatic logic [7:0] zp_operand(input int k);
        return 8'(k * 37 + 3);
    endfunction
    function automatic logic [AW-1:0] acc_addr(input int k);
        if (acc_zp(k)) return {8'h00, zp_operand(k)};
        return 16'(32'h0200 + k * 13);
    endfunction
    function automatic bit acc_wr(input int k);
        return (k % 3) == 2;
    endfunction
    function automatic logic [DW-1:0] acc_wd(input int k);
        return 8'(k * 7 + 5);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rdy = 1'b1;
        core_addr = acc_addr(0); core_we = acc_wr(0); core_wdata = acc_wd(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // One run of n_acc accesses; optional random stalls; returns a signature
    task automatic run_trace(input int n_acc, input bit stalls,
                             output logic [31:0] sig, output int wr_seen);
        int k = 0;
        bit prev_stall = 1'b0;
        bit in_burst = 1'b0;
        logic [AW-1:0] r_addr = '0;
        logic          r_we = 1'b0;
        logic [DW-1:0] r_wd = '0;
        logic [7:0]    dbus;
        bit            first;
        sig = 32'h1;
        wr_seen = 0;
        do_reset();   // leaves us just after a negedge with rst low
        while (k < n_acc) begin
            if (stalls)
                in_burst = in_burst ? (($urandom % 2) == 0) : (($urandom % 16) == 0);
            rdy = !in_burst;
            first = !rdy && !prev_stall;
            if (rdy || first) begin
                dbus = zp_operand(k);
                core_wdata = acc_wd(k);
            end else begin
                dbus = 8'($urandom);
                core_wdata = 8'($urandom);
            end
            core_addr = acc_zp(k) ? {8'h00, dbus} : acc_addr(k);
            core_we = acc_wr(k);
            #1;
            // pass-through variant
            if (rdy)
                chk(a0_addr == acc_addr(k), "R1 addr", 32'(a0_addr), 32'(acc_addr(k)));
            else if (first)
                chk(a0_addr == acc_addr(k), "R2 addr", 32'(a0_addr), 32'(acc_addr(k)));
            else
                chk(a0_addr == acc_addr(k), "R3 addr", 32'(a0_addr), 32'(acc_addr(k)));
            chk(a0_wd == acc_wd(k), rdy ? "R1 wdata" : "R4 wdata", 32'(a0_wd), 32'(acc_wd(k)));
            chk(a0_we == (rdy && acc_wr(k)), rdy ? "R1 we" : "R5 we",
                32'(a0_we), 32'(rdy && acc_wr(k)));
            if (a0_we) wr_seen++;
            if (rdy) sig = (sig * 31) ^ {7'd0, a0_we, a0_wd, a0_addr};
            // registered variant (state from previous edge)
            chk(a1_addr == r_addr, prev_stall ? "R9 addr" : "R8 addr", 32'(a1_addr), 32'(r_addr));
            chk(a1_wd == r_wd, prev_stall ? "R9 wdata" : "R8 wdata", 32'(a1_wd), 32'(r_wd));
            chk(a1_we == r_we, prev_stall ? "R9 we" : "R8 we", 32'(a1_we), 32'(r_we));
            @(posedge clk);
            if (rdy) begin
                r_addr = acc_addr(k); r_we = acc_wr(k); r_wd = acc_wd(k);
                k++;
            end else begin
                r_we = 1'b0;
            end
            prev_stall = !rdy;
            @(negedge clk);
        end
        rdy = 1'b1;
    endtask

    initial begin
        logic [31:0] sig_a, sig_b;
        int wr_a, wr_b, exp_wr;
        void'($urandom(32'd20240611));

        // R7: live during reset, outputs of registered variant cleared
        @(negedge clk);
        rst = 1'b1; rdy = 1'b0; core_addr = 16'h1234; core_wdata = 8'h5A; core_we = 1'b1;
        #1;
        chk(a0_addr == 16'h1234, "R7 live in reset", 32'(a0_addr), 32'h1234);
        chk(a0_we == 1'b0, "R7 we in reset", 32'(a0_we), 32'h0);
        @(negedge clk);
        core_addr = 16'h4321;
        #1;
        chk(a0_addr == 16'h4321, "R7 follows in reset", 32'(a0_addr), 32'h4321);
        chk(a1_addr == 16'h0 && a1_we == 1'b0 && a1_wd == 8'h0, "R7 reg cleared",
            {a1_addr, 7'd0, a1_we, a1_wd}, 32'h0);
        // release reset with stall already running: fresh first stall
        @(negedge clk);
        rst = 1'b0; core_addr = 16'hC0DE; core_wdata = 8'h3C;
        #1;
        chk(a0_addr == 16'hC0DE, "R7 R2 first after reset", 32'(a0_addr), 32'hC0DE);
        chk(a0_we == 1'b0, "R5 first stall we", 32'(a0_we), 32'h0);
        @(negedge clk);
        core_addr = 16'h00F8; core_wdata = 8'hEE;
        #1;
        chk(a0_addr == 16'hC0DE, "R3 held addr", 32'(a0_addr), 32'hC0DE);
        chk(a0_wd == 8'h3C, "R4 held wdata", 32'(a0_wd), 32'h3C);
        chk(a0_we == 1'b0, "R5 held we", 32'(a0_we), 32'h0);
        repeat (5) begin
            @(negedge clk);
            core_addr = 16'($urandom); core_wdata = 8'($urandom);
            #1;
            chk(a0_addr == 16'hC0DE, "R3 long stall", 32'(a0_addr), 32'hC0DE);
        end
        chk(a1_addr == 16'h0, "R9 reg frozen", 32'(a1_addr), 32'h0);
        @(negedge clk);
        rdy = 1'b1; core_addr = 16'hBEEF; core_wdata = 8'h77; core_we = 1'b1;
        #1;
        chk(a0_addr == 16'hBEEF, "R6 live on release", 32'(a0_addr), 32'hBEEF);
        chk(a0_we == 1'b1, "R6 we on release", 32'(a0_we), 32'h1);
        @(negedge clk);
        chk(a1_addr == 16'hBEEF && a1_we == 1'b1, "R8 reg load",
            {a1_addr, 15'd0, a1_we}, {16'hBEEF, 16'h1});

        // R10: same access list with and without stalls
        run_trace(300, 1'b0, sig_a, wr_a);
        run_trace(300, 1'b1, sig_b, wr_b);
        exp_wr = 0;
        for (int i = 0; i < 300; i++) if (acc_wr(i)) exp_wr++;
        chk(sig_a == sig_b, "R10 trace signature", sig_b, sig_a);
        chk(wr_a == exp_wr, "R5 writes no stall", 32'(wr_a), 32'(exp_wr));
        chk(wr_b == exp_wr, "R5 R10 writes once", 32'(wr_b), 32'(exp_wr));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule